// File: doc/BRIEF.md
# Prioritised Interrupt Cause Selector

This block decides which pending interrupt, if any, a hart should take next. It combines the pending and enable vectors, the delegation vector, the two global interrupt-enable bits from the status register and the current privilege level. From these it produces the exception-cause word of the single winning interrupt. Interrupts that stay at machine level are tried first. Delegated (supervisor) interrupts are tried only when no machine-level candidate exists at all.

The winner is chosen in two ways. Any candidate at bit position 12 or above beats every lower bit, and among those the lowest position wins. Below bit 12 a fixed, non-monotonic order applies, and a few positions never win. The winning position is turned into a binary index by a halving search. The result is then placed under the interrupt flag in the top bit of the cause word.

The selection logic is purely combinational. The trap-entry logic samples the result only at instruction boundaries: on a boundary strobe the block registers the cause and raises a one-cycle take request.

Top module: `irq_cause_select`

## Requirements
- R1: The pending set is `pend_i & ien_i`. When it is zero, or when no candidate wins, a boundary strobe yields `take_o`=0 and `cause_o`=0 in the following cycle.
- R2: Machine candidates are the pending bits whose `deleg_i` bit is clear. They are enabled when `priv_i` is below 3, or when `priv_i`==3 and `m_gie_i`=1. Otherwise they count as zero.
- R3: Supervisor candidates are the pending bits whose `deleg_i` bit is set. They are used only when the gated machine candidates are all zero. They are enabled when `priv_i`==0, or when `priv_i`==1 and `s_gie_i`=1.
- R4: If any selected candidate lies at position 12 or higher, all lower positions are ignored and the lowest such position wins.
- R5: Otherwise the first set position in the order 11, 3, 7, 9, 1, 5, 13, 10, 4, 6 wins.
- R6: When the selected candidates hold only positions 0, 2 and/or 8, nothing wins. A nonzero machine candidate set of that kind still blocks the supervisor set.
- R7: A winning position p gives the cause word 32'h8000_0000 | p (interrupt flag in bit 31, index in the low bits), with `take_o`=1.
- R8: Result and request are registered on a clock edge with `boundary_i`=1. `take_o` is high for exactly that one following cycle. Without a strobe `take_o` is 0 and `cause_o` keeps its last value.
- R9: During and straight after synchronous reset, `take_o`=0 and `cause_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 32 | Interrupt-pending vector |
| ien_i | input | 32 | Per-source interrupt-enable vector |
| deleg_i | input | 32 | Delegation vector (1 = supervisor-handled) |
| m_gie_i | input | 1 | Machine global interrupt enable (status bit 3) |
| s_gie_i | input | 1 | Supervisor global interrupt enable (status bit 1) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| boundary_i | input | 1 | Instruction-boundary sampling strobe |
| take_o | output | 1 | One-cycle interrupt-take request |
| cause_o | output | 32 | Registered cause word of the winning interrupt |

## Verification
The bench tries pairs and triples of low-position sources, and each set puts the expected winner behind a position that a plain lowest-first or highest-first encoder would pick. This way only the stated order passes. A second group mixes sources above and below position 12, including bit 31, which separates the high-range rule and the halving search from the low-range order. A third group keeps the pending bits fixed and varies privilege, the two global enables and the delegation vector. It shows when machine candidates mask supervisor ones, including the case where a machine set holding only non-winning positions blocks delegated sources. Directed tests cover reset, strobe-less cycles and the single-cycle width of the request.

// File: rtl/irq_sel_pkg.sv
// Package: shared widths and the fixed low-range priority order for the
// interrupt cause selector. Assumes a 32-bit cause word.
package irq_sel_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned IDX_W     = $clog2(XLEN);
    localparam int unsigned HIGH_BASE = 12;
    localparam int unsigned PRIO_N    = 10;
    // first entry wins; positions >= HIGH_BASE are never reached here
    localparam int unsigned PRIO_ORDER [PRIO_N] = '{11, 3, 7, 9, 1, 5, 13, 10, 4, 6};

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;
endpackage

// File: rtl/irq_gate.sv
// irq_gate: forms the candidate set. Machine-level sources (not delegated)
// are enabled by privilege and the machine global enable; delegated sources
// are used only when the gated machine set is empty.
// Assumes priv_i encodes 0/1/3 as user/supervisor/machine.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] ien_i,
    input  logic [W-1:0] deleg_i,
    input  logic         m_gie_i,
    input  logic         s_gie_i,
    input  logic [1:0]   priv_i,
    output logic [W-1:0] cand_o
);
    logic [W-1:0] live;
    logic [W-1:0] m_cand;
    logic [W-1:0] s_cand;
    logic         m_on;
    logic         s_on;

    // Purpose: privilege-dependent enables for both levels.
    always_comb begin
        m_on = (priv_i != PRIV_M) || m_gie_i;
        s_on = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_gie_i);
    end

    // Purpose: gate the pending set per level and pick machine first.
    always_comb begin
        live   = pend_i & ien_i;
        m_cand = live & ~deleg_i & {W{m_on}};
        s_cand = live &  deleg_i & {W{s_on}};
        cand_o = (m_cand != '0) ? m_cand : s_cand;
    end

    // Purpose: at machine level with the global enable off, only delegated bits may appear.
    always_comb begin
        assert_mlevel_masked_R2: assert (!((priv_i == PRIV_M) && !m_gie_i) || ((cand_o & ~deleg_i) == '0));
    end
endmodule

// File: rtl/irq_prio_pick.sv
// irq_prio_pick: reduces the candidate set to a one-hot winner. Positions at
// or above HIGH_BASE win lowest-first; below it a fixed order applies and
// unlisted positions never win.
module irq_prio_pick
    import irq_sel_pkg::*;
#(
    parameter int unsigned W     = XLEN,
    parameter int unsigned SPLIT = HIGH_BASE
) (
    input  logic [W-1:0] cand_i,
    output logic [W-1:0] win_o
);
    localparam int unsigned IW       = $clog2(W);
    localparam logic [W-1:0] LOW_MSK = (W'(1) << SPLIT) - W'(1);

    logic [W-1:0] hi;
    logic         hit;

    // Purpose: high range lowest-first, otherwise walk the fixed order.
    always_comb begin
        hi    = cand_i & ~LOW_MSK;
        win_o = '0;
        hit   = 1'b0;
        if (hi != '0) begin
            win_o = hi & (~hi + W'(1));
        end else begin
            for (int k = 0; k < PRIO_N; k++) begin
                if (!hit && cand_i[IW'(PRIO_ORDER[k])]) begin
                    win_o[IW'(PRIO_ORDER[k])] = 1'b1;
                    hit = 1'b1;
                end
            end
        end
    end

    // Purpose: at most one winner, always drawn from the candidates.
    always_comb begin
        assert_single_winner_R5: assert ($onehot0(win_o) && ((win_o & ~cand_i) == '0));
    end
endmodule

// File: rtl/irq_bit_index.sv
// irq_bit_index: trailing-zero count by halving search (steps W/2 .. 1).
// A zero input yields index 0. Assumes W is a power of two.
module irq_bit_index #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         val_i,
    output logic [$clog2(W)-1:0] idx_o
);
    localparam int unsigned IW = $clog2(W);

    logic [W-1:0]  v;
    logic [IW-1:0] acc;
    logic [W-1:0]  lowmsk;

    // Purpose: halve the search window while its low part is empty.
    always_comb begin
        v      = val_i;
        acc    = '0;
        lowmsk = '0;
        for (int l = 0; l < IW; l++) begin
            lowmsk = (W'(1) << (W >> (l + 1))) - W'(1);
            if ((v & lowmsk) == '0) begin
                v   = v >> (W >> (l + 1));
                acc = acc + IW'(W >> (l + 1));
            end
        end
        idx_o = (val_i == '0) ? '0 : acc;
    end

    // Purpose: a one-hot input must map onto its own set position.
    always_comb begin
        assert_index_hits_bit_R7: assert (!$onehot(val_i) || val_i[idx_o]);
    end
endmodule

// File: rtl/irq_cause_select.sv
// irq_cause_select: top. Gates, prioritises and encodes the interrupt cause,
// then registers cause and a one-cycle take request on the boundary strobe.
// Assumes boundary_i is synchronous to clk; reset is synchronous, active low.
module irq_cause_select
    import irq_sel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] ien_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic            m_gie_i,
    input  logic            s_gie_i,
    input  logic [1:0]      priv_i,
    input  logic            boundary_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int unsigned W  = XLEN;
    localparam int unsigned IW = IDX_W;

    logic [W-1:0]  cand;
    logic [W-1:0]  win;
    logic [IW-1:0] idx;
    logic          any;
    logic [W-1:0]  cause_d;

    irq_gate #(.W(W)) u_gate (
        .pend_i (pend_i),
        .ien_i  (ien_i),
        .deleg_i(deleg_i),
        .m_gie_i(m_gie_i),
        .s_gie_i(s_gie_i),
        .priv_i (priv_i),
        .cand_o (cand)
    );

    irq_prio_pick #(.W(W), .SPLIT(HIGH_BASE)) u_pick (
        .cand_i(cand),
        .win_o (win)
    );

    irq_bit_index #(.W(W)) u_index (
        .val_i(win),
        .idx_o(idx)
    );

    // Purpose: build the cause word with the interrupt flag on top.
    always_comb begin
        any     = (win != '0);
        cause_d = any ? {1'b1, {(W - 1 - IW){1'b0}}, idx} : '0;
    end

    // Purpose: sample on the instruction boundary; request lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            cause_o <= '0;
        end else if (boundary_i) begin
            take_o  <= any;
            cause_o <= cause_d;
        end else begin
            take_o  <= 1'b0;
        end
    end

    assert_take_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[W-1]);
    assert_no_take_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> !take_o);
    assert_cause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> $stable(cause_o));
    assert_nothing_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && ((pend_i & ien_i) == '0)) |=> (!take_o && cause_o == '0));
endmodule

// File: tb/tb_irq_cause_select.sv
module tb_irq_cause_select;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] pend;
        logic [31:0] ien;
        logic [31:0] deleg;
        logic        mgie;
        logic        sgie;
        logic [1:0]  priv;
        logic [31:0] cause;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{32'h0,        32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h0,         4'd1}, // R1 nothing pending
        '{32'h888,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_000B, 4'd5}, // R5 11 over 3,7
        '{32'h0AA,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_0003, 4'd5}, // R5 3 over 1,5,7
        '{32'h2A0,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_0007, 4'd5}, // R5 7 over 5,9
        '{32'h006,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_0001, 4'd5}, // R5 1 over 2
        '{32'h450,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_000A, 4'd5}, // R5 10 over 4,6
        '{32'h050,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_0004, 4'd5}, // R5 4 over 6
        '{32'h0003_0808,32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_0010, 4'd4}, // R4 16 beats 11
        '{32'h8000_1000,32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_000C, 4'd4}, // R4 lowest high
        '{32'h8000_0000,32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_001F, 4'd7}, // R7 bit 31
        '{32'h105,      32'hFFFF_FFFF, 32'h0,     1'b1, 1'b0, 2'd3, 32'h0,         4'd6}, // R6 unlisted only
        '{32'h888,      32'h0000_0008, 32'h0,     1'b1, 1'b0, 2'd3, 32'h8000_0003, 4'd1}, // R1 enable mask
        '{32'h800,      32'hFFFF_FFFF, 32'h0,     1'b0, 1'b0, 2'd3, 32'h0,         4'd2}, // R2 mgie off at M
        '{32'h800,      32'hFFFF_FFFF, 32'h0,     1'b0, 1'b0, 2'd1, 32'h8000_000B, 4'd2}, // R2 lower priv on
        '{32'h202,      32'hFFFF_FFFF, 32'h200,   1'b1, 1'b0, 2'd3, 32'h8000_0001, 4'd2}, // R2 deleg removes 9
        '{32'h202,      32'hFFFF_FFFF, 32'h202,   1'b0, 1'b1, 2'd1, 32'h8000_0009, 4'd3}, // R3 S with sgie
        '{32'h202,      32'hFFFF_FFFF, 32'h202,   1'b0, 1'b0, 2'd1, 32'h0,         4'd3}, // R3 S without sgie
        '{32'h202,      32'hFFFF_FFFF, 32'h202,   1'b0, 1'b0, 2'd0, 32'h8000_0009, 4'd3}, // R3 from U
        '{32'h202,      32'hFFFF_FFFF, 32'h202,   1'b1, 1'b1, 2'd3, 32'h0,         4'd3}, // R3 never at M
        '{32'h300,      32'hFFFF_FFFF, 32'h200,   1'b0, 1'b1, 2'd1, 32'h0,         4'd6}, // R6 bit 8 blocks S
        '{32'h2200,     32'hFFFF_FFFF, 32'h200,   1'b0, 1'b1, 2'd1, 32'h8000_000D, 4'd4}  // R4 machine 13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pend_i = '0, ien_i = '0, deleg_i = '0;
    logic        m_gie_i = 1'b0, s_gie_i = 1'b0, boundary_i = 1'b0;
    logic [1:0]  priv_i = 2'd0;
    logic        take_o;
    logic [31:0] cause_o;

    int checks = 0;
    int fails  = 0;

    irq_cause_select dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .ien_i(ien_i), .deleg_i(deleg_i),
        .m_gie_i(m_gie_i), .s_gie_i(s_gie_i), .priv_i(priv_i),
        .boundary_i(boundary_i), .take_o(take_o), .cause_o(cause_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        pend_i = v.pend; ien_i = v.ien; deleg_i = v.deleg;
        m_gie_i = v.mgie; s_gie_i = v.sgie; priv_i = v.priv;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 take in reset", {31'b0, take_o}, 32'h0);
        check("R9 cause in reset", cause_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 take after reset", {31'b0, take_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            load(VEC[i]);
            boundary_i = 1'b1;
            @(negedge clk);
            boundary_i = 1'b0;
            check($sformatf("R%0d vec%0d cause", VEC[i].req, i), cause_o, VEC[i].cause);
            check($sformatf("R%0d vec%0d take", VEC[i].req, i), {31'b0, take_o},
                  {31'b0, (VEC[i].cause != 32'h0)});
        end

        // R8: request lasts one cycle; a strobe-less cycle keeps the cause
        load(VEC[1]);
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        check("R8 take pulse", {31'b0, take_o}, 32'h1);
        load(VEC[2]);
        @(negedge clk);
        check("R8 take drops", {31'b0, take_o}, 32'h0);
        check("R8 cause held", cause_o, 32'h8000_000B);
        @(negedge clk);
        check("R8 still idle", {31'b0, take_o}, 32'h0);

        // R9: reset clears a captured cause
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 cause cleared", cause_o, 32'h0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule